// File: doc/BRIEF.md
# Reset Vector Fetch Sequencer

This block runs the processor-side start-up sequence that follows a reset. While the active-low reset input is low, it keeps every output in its idle state: no memory reads, the program counter at zero, the interrupt-mask flag clear, and the run flag low. A reset that goes low takes effect at once, whatever the clock is doing.

When reset goes high, the release passes through a two-flop synchronizer. The sequencer then sets the interrupt-mask flag. Next it reads the start-address vector one byte per cycle, from the four lowest byte addresses, over a synchronous read port with one cycle of latency. The fetched bytes are assembled most-significant-first. The low 24 bits of the result are loaded into the program counter. In the same clock edge the run flag is raised, and it stays high, so instruction fetch can begin from that address.

If reset goes low again at any point, the sequence stops immediately. A later release starts it again from the beginning.

Top module: `rst_vec_seq`

## Requirements
- R1: While `rstN` is low, `memRdEn` is 0, `run` is 0, `intMask` is 0 and `pc` is 0.
- R2: No read is issued until a release has passed the two-flop synchronizer. The first read request appears after the fourth rising clock edge that follows `rstN` going high. A release that lasts across only one rising edge starts nothing.
- R3: `intMask` becomes 1 no later than the first read request. It is 1 in every cycle in which `memRdEn` is 1, and it stays 1 until the next reset.
- R4: The sequence issues exactly four read requests, in four consecutive cycles, to addresses 0, 1, 2 and 3 in that order. `memAddr` advances by one on each request.
- R5: The read port has a one-cycle latency. The byte for a request is taken from `memRdata` in the cycle after that request, and the value of `memRdata` in any other cycle has no effect.
- R6: The vector is big-endian: the byte at address 0 is the most significant. The 32-bit value is truncated to 24 bits, so `pc` equals {byte1, byte2, byte3}.
- R7: `pc` is loaded and `run` rises at the tenth rising edge after release. After that, `run` stays 1, `pc` does not change, and no further reads are issued.
- R8: A low level on `rstN` in the middle of the sequence or after it returns all outputs to the R1 values at once. The next release runs a complete new sequence.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Raw active-low reset, asynchronous assertion |
| memRdata | input | 8 | Read data, valid the cycle after a request |
| memRdEn | output | 1 | Read request strobe |
| memAddr | output | 24 | Byte address of the read request |
| pc | output | 24 | Program counter |
| intMask | output | 1 | Interrupt-mask flag of the condition code |
| run | output | 1 | Instruction fetch may begin |

## Verification
The assertions assume that `rstN` changes away from rising clock edges. They also assume that the memory answers every request exactly one cycle later. The bench changes `rstN` only on falling edges. Its memory model registers read data on the rising edge after each request and drives a filler byte in every other cycle, so capturing data in the wrong cycle shows up as a wrong program counter. Abort and glitch cases drop `rstN` on a falling edge in the middle of the fetch, during run, and after a single rising edge of release.

// File: rtl/rvs_pkg.sv
`timescale 1ns/1ps
package rvs_pkg;

  typedef enum logic [2:0] {
    ST_HOLD,
    ST_MASK,
    ST_FETCH,
    ST_DRAIN,
    ST_LOAD,
    ST_RUN
  } seqState_e;

  // Strobes from control to datapath
  typedef struct packed {
    logic setMask;
    logic issueRd;
    logic loadPc;
  } seqStrobe_t;

endpackage

// File: rtl/rvs_sync.sv
`timescale 1ns/1ps
module rvs_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  output logic relSync
);

  logic [STAGES-1:0] chain;

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) chain <= '0;
        else       chain <= 1'b1;
      end
    end else begin : g_multi
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) chain <= '0;
        else       chain <= {chain[STAGES-2:0], 1'b1};
      end
    end
  endgenerate

  assign relSync = chain[STAGES-1];

endmodule

// File: rtl/rvs_ctrl.sv
`timescale 1ns/1ps
module rvs_ctrl
  import rvs_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       relSync,
  input  logic       lastIssue,
  output seqStrobe_t strobe
);

  seqState_e state, stateNext;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_HOLD;
    else       state <= stateNext;
  end

  always_comb begin
    stateNext = state;
    unique case (state)
      ST_HOLD:  if (relSync) stateNext = ST_MASK;
      ST_MASK:  stateNext = ST_FETCH;
      ST_FETCH: if (lastIssue) stateNext = ST_DRAIN;
      ST_DRAIN: stateNext = ST_LOAD;
      ST_LOAD:  stateNext = ST_RUN;
      ST_RUN:   stateNext = ST_RUN;
      default:  stateNext = ST_HOLD;
    endcase
  end

  always_comb begin
    strobe         = '0;
    strobe.setMask = (state == ST_MASK);
    strobe.issueRd = (state == ST_FETCH);
    strobe.loadPc  = (state == ST_LOAD);
  end

endmodule

// File: rtl/rvs_datapath.sv
`timescale 1ns/1ps
module rvs_datapath
  import rvs_pkg::*;
#(
  parameter int ADDR_W    = 24,
  parameter int DATA_W    = 8,
  parameter int PC_W      = 24,
  parameter int VEC_BYTES = 4,
  parameter int VEC_BASE  = 0
) (
  input  logic              clk,
  input  logic              rstN,
  input  seqStrobe_t        strobe,
  input  logic [DATA_W-1:0] memRdata,
  output logic              lastIssue,
  output logic              memRdEn,
  output logic [ADDR_W-1:0] memAddr,
  output logic [PC_W-1:0]   pc,
  output logic              intMask,
  output logic              run
);

  localparam int IDX_W = (VEC_BYTES > 1) ? $clog2(VEC_BYTES) : 1;

  logic [IDX_W-1:0] rdIdx;
  logic             rdPend;
  logic [PC_W-1:0]  asmReg;
  logic [PC_W-1:0]  pcReg;
  logic             maskReg;
  logic             runReg;

  assign lastIssue = (rdIdx == IDX_W'(VEC_BYTES - 1));
  assign memRdEn   = strobe.issueRd;
  assign memAddr   = strobe.issueRd ? (ADDR_W'(VEC_BASE) + ADDR_W'(rdIdx)) : '0;

  // Issue side and status flags
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rdIdx   <= '0;
      rdPend  <= 1'b0;
      maskReg <= 1'b0;
      pcReg   <= '0;
      runReg  <= 1'b0;
    end else begin
      rdPend <= strobe.issueRd;
      if (strobe.issueRd) rdIdx   <= rdIdx + 1'b1;
      if (strobe.setMask) maskReg <= 1'b1;
      if (strobe.loadPc) begin
        pcReg  <= asmReg;
        runReg <= 1'b1;
      end
    end
  end

  // Byte assembly, most significant first; older bytes fall off the top
  generate
    if (PC_W > DATA_W) begin : g_shift
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN)       asmReg <= '0;
        else if (rdPend) asmReg <= {asmReg[PC_W-DATA_W-1:0], memRdata};
      end
    end else begin : g_narrow
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN)       asmReg <= '0;
        else if (rdPend) asmReg <= memRdata[PC_W-1:0];
      end
    end
  endgenerate

  assign pc      = pcReg;
  assign intMask = maskReg;
  assign run     = runReg;

endmodule

// File: rtl/rst_vec_seq.sv
`timescale 1ns/1ps
module rst_vec_seq
  import rvs_pkg::*;
#(
  parameter int ADDR_W      = 24,
  parameter int DATA_W      = 8,
  parameter int PC_W        = 24,
  parameter int VEC_BYTES   = 4,
  parameter int VEC_BASE    = 0,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [DATA_W-1:0] memRdata,
  output logic              memRdEn,
  output logic [ADDR_W-1:0] memAddr,
  output logic [PC_W-1:0]   pc,
  output logic              intMask,
  output logic              run
);

  logic       relSync;
  logic       lastIssue;
  seqStrobe_t strobe;

  rvs_sync #(.STAGES(SYNC_STAGES)) uSync (
    .clk     (clk),
    .rstN    (rstN),
    .relSync (relSync)
  );

  rvs_ctrl uCtrl (
    .clk       (clk),
    .rstN      (rstN),
    .relSync   (relSync),
    .lastIssue (lastIssue),
    .strobe    (strobe)
  );

  rvs_datapath #(
    .ADDR_W    (ADDR_W),
    .DATA_W    (DATA_W),
    .PC_W      (PC_W),
    .VEC_BYTES (VEC_BYTES),
    .VEC_BASE  (VEC_BASE)
  ) uDp (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .memRdata  (memRdata),
    .lastIssue (lastIssue),
    .memRdEn   (memRdEn),
    .memAddr   (memAddr),
    .pc        (pc),
    .intMask   (intMask),
    .run       (run)
  );

endmodule

// File: rtl/rvs_checker.sv
`timescale 1ns/1ps
module rvs_checker #(
  parameter int ADDR_W   = 24,
  parameter int PC_W     = 24,
  parameter int VEC_BASE = 0
) (
  input logic              clk,
  input logic              rstN,
  input logic              memRdEn,
  input logic [ADDR_W-1:0] memAddr,
  input logic [PC_W-1:0]   pc,
  input logic              intMask,
  input logic              run
);

  AST_HELD_IDLE: assert property (@(posedge clk)
    !rstN |-> (!memRdEn && !run && !intMask && pc == '0)); // R1

  AST_MASK_ON_READ: assert property (@(posedge clk) disable iff (!rstN)
    memRdEn |-> intMask); // R3

  AST_MASK_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    intMask |=> intMask); // R3

  AST_FIRST_ADDR: assert property (@(posedge clk) disable iff (!rstN)
    (memRdEn && !$past(memRdEn)) |-> memAddr == ADDR_W'(VEC_BASE)); // R4

  AST_ADDR_STEP: assert property (@(posedge clk) disable iff (!rstN)
    (memRdEn && $past(memRdEn)) |-> memAddr == $past(memAddr) + 1'b1); // R4

  AST_RUN_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    run |=> run); // R7

  AST_NO_READ_RUN: assert property (@(posedge clk) disable iff (!rstN)
    run |-> (!memRdEn && intMask)); // R7

  AST_PC_FROZEN: assert property (@(posedge clk) disable iff (!rstN)
    (run && $past(run)) |-> $stable(pc)); // R7

endmodule

bind rst_vec_seq rvs_checker #(
  .ADDR_W   (ADDR_W),
  .PC_W     (PC_W),
  .VEC_BASE (VEC_BASE)
) uChk (
  .clk     (clk),
  .rstN    (rstN),
  .memRdEn (memRdEn),
  .memAddr (memAddr),
  .pc      (pc),
  .intMask (intMask),
  .run     (run)
);

// File: tb/tb_rst_vec_seq.sv
`timescale 1ns/1ps
module tb_rst_vec_seq;

  logic        clk = 1'b0;
  logic        rstN;
  logic [7:0]  memRdata;
  logic        memRdEn;
  logic [23:0] memAddr;
  logic [23:0] pc;
  logic        intMask;
  logic        run;

  int checks = 0;
  int fails  = 0;

  logic [7:0]  vecMem [4];
  logic [23:0] addrQ [$];
  logic [23:0] pcQ   [$];
  bit          skipScore = 1'b0;
  bit          prevRun   = 1'b0;

  always #2 clk = ~clk;

  rst_vec_seq dut (
    .clk      (clk),
    .rstN     (rstN),
    .memRdata (memRdata),
    .memRdEn  (memRdEn),
    .memAddr  (memAddr),
    .pc       (pc),
    .intMask  (intMask),
    .run      (run)
  );

  // Memory model: one-cycle latency, filler byte when not read (R5)
  always @(posedge clk) begin
    if (memRdEn)
      memRdata <= (memAddr < 24'd4) ? vecMem[memAddr[1:0]] : 8'hEE;
    else
      memRdata <= 8'h5A;
  end

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // Monitor: pops scoreboard items as the design produces them
  always @(negedge clk) begin
    if (!rstN) begin
      prevRun = 1'b0;
    end else if (!skipScore) begin
      if (memRdEn) begin
        if (addrQ.size() == 0) begin
          check(1'b0, "R7", "read after sequence end", memAddr, 0);
        end else begin
          logic [23:0] ea;
          ea = addrQ.pop_front();
          check(memAddr == ea, "R4", "read address", memAddr, ea);
          check(intMask == 1'b1, "R3", "mask during read", intMask, 1);
        end
      end
      if (run && !prevRun) begin
        if (pcQ.size() == 0) begin
          check(1'b0, "R7", "unexpected run", pc, 0);
        end else begin
          logic [23:0] ep;
          ep = pcQ.pop_front();
          check(pc == ep, "R6", "loaded pc", pc, ep);
        end
      end
      prevRun = run;
    end
  end

  task automatic holdReset(input int n);
    @(negedge clk);
    rstN = 1'b0;
    #0.1;
    check(!memRdEn && !run && !intMask && pc == 24'h0, "R8", "immediate idle on reset",
          {run, intMask, memRdEn}, 0);
    repeat (n) @(negedge clk);
    check(memRdEn == 1'b0, "R1", "no read in reset", memRdEn, 0);
    check(run == 1'b0,     "R1", "run in reset",     run, 0);
    check(intMask == 1'b0, "R1", "mask in reset",    intMask, 0);
    check(pc == 24'h0,     "R1", "pc in reset",      pc, 0);
  endtask

  // Driver: loads the vector, pushes expected items, releases reset
  task automatic bootRun(input logic [7:0] b0, input logic [7:0] b1,
                         input logic [7:0] b2, input logic [7:0] b3);
    logic [23:0] expPc;
    vecMem[0] = b0; vecMem[1] = b1; vecMem[2] = b2; vecMem[3] = b3;
    expPc = {b1, b2, b3};
    for (int a = 0; a < 4; a++) addrQ.push_back(24'(a));
    pcQ.push_back(expPc);
    rstN = 1'b1;
    for (int k = 1; k <= 10; k++) begin
      @(negedge clk);
      check(memRdEn == (k >= 4 && k <= 7), "R2", $sformatf("read strobe edge %0d", k),
            memRdEn, (k >= 4 && k <= 7));
      check(intMask == (k >= 4), "R3", $sformatf("mask edge %0d", k), intMask, (k >= 4));
      check(run == (k >= 10), "R7", $sformatf("run edge %0d", k), run, (k >= 10));
    end
    repeat (6) @(negedge clk);
    check(run == 1'b1, "R7", "run held", run, 1);
    check(pc == expPc, "R7", "pc held", pc, expPc);
    check(pcQ.size() == 0 && addrQ.size() == 0, "R4", "scoreboard drained",
          addrQ.size() + pcQ.size(), 0);
  endtask

  task automatic abortRun(input int n);
    skipScore = 1'b1;
    vecMem[0] = 8'h11; vecMem[1] = 8'h22; vecMem[2] = 8'h33; vecMem[3] = 8'h44;
    rstN = 1'b1;
    repeat (n) @(negedge clk);
    holdReset(3);
    skipScore = 1'b0;
  endtask

  initial begin : mainSeq
    rstN = 1'b0;
    for (int i = 0; i < 4; i++) vecMem[i] = 8'h00;
    repeat (4) @(negedge clk);
    check(!memRdEn && !run && !intMask && pc == 24'h0, "R1", "power-up idle",
          {run, intMask, memRdEn}, 0);

    bootRun(8'hA5, 8'h12, 8'h34, 8'h56);       // R6 top byte dropped
    holdReset(3);                              // R8 reset during run
    bootRun(8'h00, 8'hFF, 8'hFF, 8'hFF);
    holdReset(2);

    // R2: release seen by only one rising edge starts nothing
    skipScore = 1'b1;
    rstN = 1'b1;
    @(negedge clk);
    rstN = 1'b0;
    skipScore = 1'b0;
    repeat (8) begin
      @(negedge clk);
      check(!memRdEn && !intMask, "R2", "short release ignored",
            {memRdEn, intMask}, 0);
    end

    abortRun(6);                               // R8 mid-fetch
    bootRun(8'h7E, 8'h00, 8'h00, 8'h01);
    holdReset(2);
    abortRun(2);                               // R8 before fetch
    bootRun(8'hFF, 8'hC3, 8'h5A, 8'h0F);       // R5 filler 5A never leaks

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule